// File: doc/BRIEF.md
# Status Byte and Service Request Logic

This block builds the eight-bit status byte of a bus-controlled instrument from summary inputs supplied by the surrounding status system. These inputs are a condition-summary vector, two event/enable vector pairs (questionable and operation), an output-data-ready flag and a standard-event summary bit. A service request enable register is loaded through a single-cycle write port. From the status byte and that enable register the block forms the master summary. It then derives a latched request-service bit and drives an active-high service request line from it.

Two read paths share one sixteen-bit readout. A serial-poll read places request-service in bit 6. A status-query read places the master summary there. Neither read alters any status state. The status byte is registered once per cycle from the current inputs. Readout data is registered on the cycle after the request, and the upper byte always reads as zero.

Top module: `sb_status_top`

## Requirements
- R1: In every readout, bits 0, 1 and 8 to 15 of `rd_data_o` are zero.
- R2: One clock after the inputs are applied, status bit 2 equals the OR of all `cond_i` bits, status bit 4 equals `mav_i` and status bit 5 equals `esb_i`.
- R3: One clock after the inputs are applied, status bit 3 equals the OR over all positions of `ques_evt_i & ques_en_i`, and status bit 7 equals the OR over all positions of `oper_evt_i & oper_en_i`.
- R4: The master summary is the OR of (status bit n AND enable bit n) for n in {0,1,2,3,4,5,7`}`. An enabled status bit that is clear contributes nothing.
- R5: Request-service sets on the clock after the master summary goes from false to true, and `srq_o` is high whenever request-service is set.
- R6: Request-service clears on the clock after the master summary is false, and a synchronous reset clears it.
- R7: A write with `sre_we_i` high loads `sre_wdata_i` into the enable register with bit 6 forced to zero, visible on `sre_o` one clock later. The register resets to zero.
- R8: A serial poll (`poll_req_i` high for one clock) gives `rd_vld_o` high on the next clock, with `rd_data_o[7:0]` equal to the status byte and bit 6 replaced by request-service, both taken at the request edge.
- R9: A status query (`query_req_i` high) gives the same readout, except that bit 6 carries the master summary at the request edge.
- R10: A serial poll or a status query leaves `srq_o` and later readouts unchanged.
- R11: When both requests are high in the same clock, the serial-poll format is returned.
- R12: During and just after reset, `rd_vld_o`, `rd_data_o`, `srq_o` and `sre_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | COND_W | Condition-summary register bits |
| ques_evt_i | input | QUES_W | Questionable event bits |
| ques_en_i | input | QUES_W | Questionable enable bits |
| oper_evt_i | input | OPER_W | Operation event bits |
| oper_en_i | input | OPER_W | Operation enable bits |
| mav_i | input | 1 | Output data ready to send |
| esb_i | input | 1 | Standard-event summary |
| sre_we_i | input | 1 | Enable register write strobe |
| sre_wdata_i | input | 8 | Enable register write data |
| sre_o | output | 8 | Enable register contents |
| poll_req_i | input | 1 | Serial-poll read request |
| query_req_i | input | 1 | Status-query read request |
| rd_data_o | output | 16 | Readout word |
| rd_vld_o | output | 1 | Readout valid, one clock per request |
| srq_o | output | 1 | Service request line |

## Verification
The assertions assume that the inputs change only between clock edges and that reset is held for at least one edge before any check matters. Under those conditions request-service always tracks the master summary one cycle later, so the edge properties hold. The stimulus meets this by driving every input on the falling edge and starting with a multi-cycle reset. Read requests are given as single-cycle pulses so that each readout can be tied to one request edge. The enable-register writes include all-ones data, so that the forced-zero bit 6 is exercised.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int SB_W   = 8;
  localparam int RD_W   = 16;
  localparam int B_CSUM = 2;
  localparam int B_QSUM = 3;
  localparam int B_MAV  = 4;
  localparam int B_ESB  = 5;
  localparam int B_REQ  = 6;
  localparam int B_OSUM = 7;

  localparam logic [SB_W-1:0] SUM_MASK = ~(SB_W'(1) << B_REQ);

  function automatic logic [RD_W-1:0] pack_rd(input logic [SB_W-1:0] s, input logic b6);
    logic [RD_W-1:0] r;
    r          = '0;
    r[SB_W-1:0] = s;
    r[B_REQ]   = b6;
    r[1:0]     = 2'b00;
    return r;
  endfunction
endpackage

// File: rtl/sb_event_sum.sv
module sb_event_sum #(
  parameter int W = 16
) (
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] en_i,
  output logic         hit_o
);
  always_comb hit_o = |(evt_i & en_i);
endmodule

// File: rtl/sb_summary.sv
module sb_summary
  import sb_pkg::*;
#(
  parameter int COND_W = 8,
  parameter int QUES_W = 16,
  parameter int OPER_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COND_W-1:0] cond_i,
  input  logic [QUES_W-1:0] ques_evt_i,
  input  logic [QUES_W-1:0] ques_en_i,
  input  logic [OPER_W-1:0] oper_evt_i,
  input  logic [OPER_W-1:0] oper_en_i,
  input  logic              mav_i,
  input  logic              esb_i,
  output logic [SB_W-1:0]   stb_o
);
  logic q_hit, o_hit;
  logic [SB_W-1:0] nxt;

  sb_event_sum #(.W(QUES_W)) u_ques (.evt_i(ques_evt_i), .en_i(ques_en_i), .hit_o(q_hit));
  sb_event_sum #(.W(OPER_W)) u_oper (.evt_i(oper_evt_i), .en_i(oper_en_i), .hit_o(o_hit));

  always_comb begin
    nxt         = '0;
    nxt[B_CSUM] = |cond_i;
    nxt[B_QSUM] = q_hit;
    nxt[B_MAV]  = mav_i;
    nxt[B_ESB]  = esb_i;
    nxt[B_OSUM] = o_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) stb_o <= '0;
    else     stb_o <= nxt;
  end
endmodule

// File: rtl/sb_sre_reg.sv
module sb_sre_reg
  import sb_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            we_i,
  input  logic [SB_W-1:0] wdata_i,
  output logic [SB_W-1:0] sre_o
);
  for (genvar i = 0; i < SB_W; i++) begin : g_bit
    if (i == B_REQ) begin : g_fixed
      assign sre_o[i] = 1'b0;
    end else begin : g_store
      logic q;
      always_ff @(posedge clk) begin
        if (rst)       q <= 1'b0;
        else if (we_i) q <= wdata_i[i];
      end
      assign sre_o[i] = q;
    end
  end
endmodule

// File: rtl/sb_request.sv
module sb_request
  import sb_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [SB_W-1:0] stb_i,
  input  logic [SB_W-1:0] sre_i,
  output logic            mss_o,
  output logic            rqs_o
);
  logic mss_prev;

  always_comb mss_o = |(stb_i & sre_i & SUM_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      mss_prev <= 1'b0;
      rqs_o    <= 1'b0;
    end else begin
      mss_prev <= mss_o;
      if (!mss_o)        rqs_o <= 1'b0;
      else if (!mss_prev) rqs_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sb_readout.sv
module sb_readout
  import sb_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            poll_req_i,
  input  logic            query_req_i,
  input  logic [SB_W-1:0] stb_i,
  input  logic            rqs_i,
  input  logic            mss_i,
  output logic [RD_W-1:0] rd_data_o,
  output logic            rd_vld_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
      rd_vld_o  <= 1'b0;
    end else begin
      rd_vld_o <= poll_req_i | query_req_i;
      if (poll_req_i)       rd_data_o <= pack_rd(stb_i, rqs_i);
      else if (query_req_i) rd_data_o <= pack_rd(stb_i, mss_i);
    end
  end
endmodule

// File: rtl/sb_status_top.sv
module sb_status_top
  import sb_pkg::*;
#(
  parameter int COND_W = 8,
  parameter int QUES_W = 16,
  parameter int OPER_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COND_W-1:0] cond_i,
  input  logic [QUES_W-1:0] ques_evt_i,
  input  logic [QUES_W-1:0] ques_en_i,
  input  logic [OPER_W-1:0] oper_evt_i,
  input  logic [OPER_W-1:0] oper_en_i,
  input  logic              mav_i,
  input  logic              esb_i,
  input  logic              sre_we_i,
  input  logic [7:0]        sre_wdata_i,
  output logic [7:0]        sre_o,
  input  logic              poll_req_i,
  input  logic              query_req_i,
  output logic [15:0]       rd_data_o,
  output logic              rd_vld_o,
  output logic              srq_o
);
  logic [SB_W-1:0] stb_w;
  logic            mss_w;
  logic            rqs_w;

  sb_summary #(.COND_W(COND_W), .QUES_W(QUES_W), .OPER_W(OPER_W)) u_sum (
    .clk(clk), .rst(rst), .cond_i(cond_i),
    .ques_evt_i(ques_evt_i), .ques_en_i(ques_en_i),
    .oper_evt_i(oper_evt_i), .oper_en_i(oper_en_i),
    .mav_i(mav_i), .esb_i(esb_i), .stb_o(stb_w)
  );

  sb_sre_reg u_sre (
    .clk(clk), .rst(rst), .we_i(sre_we_i), .wdata_i(sre_wdata_i), .sre_o(sre_o)
  );

  sb_request u_req (
    .clk(clk), .rst(rst), .stb_i(stb_w), .sre_i(sre_o), .mss_o(mss_w), .rqs_o(rqs_w)
  );

  sb_readout u_rd (
    .clk(clk), .rst(rst), .poll_req_i(poll_req_i), .query_req_i(query_req_i),
    .stb_i(stb_w), .rqs_i(rqs_w), .mss_i(mss_w),
    .rd_data_o(rd_data_o), .rd_vld_o(rd_vld_o)
  );

  assign srq_o = rqs_w;
endmodule

// File: rtl/sb_status_chk.sv
module sb_status_chk (
  input logic        clk,
  input logic        rst,
  input logic        poll_req_i,
  input logic        query_req_i,
  input logic [15:0] rd_data_o,
  input logic        rd_vld_o,
  input logic        srq_o,
  input logic [7:0]  sre_o,
  input logic [7:0]  stb,
  input logic        mss
);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    rd_vld_o |-> (rd_data_o[15:8] == 8'h00 && rd_data_o[1:0] == 2'b00));

  a_r4_mss_needs_enabled_bit: assert property (@(posedge clk) disable iff (rst)
    mss |-> ((stb & sre_o) != 8'h00));

  a_r5_rqs_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(mss) |=> srq_o);

  a_r6_rqs_clears: assert property (@(posedge clk) disable iff (rst)
    !mss |=> !srq_o);

  a_r7_sre_bit6_zero: assert property (@(posedge clk) disable iff (rst)
    sre_o[6] == 1'b0);

  a_r8_poll_bit6: assert property (@(posedge clk) disable iff (rst)
    poll_req_i |=> (rd_vld_o && rd_data_o[6] == $past(srq_o)));

  a_r9_query_bit6: assert property (@(posedge clk) disable iff (rst)
    (query_req_i && !poll_req_i) |=> (rd_vld_o && rd_data_o[6] == $past(mss)));

  a_r12_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    (!poll_req_i && !query_req_i) |=> !rd_vld_o);
endmodule

bind sb_status_top sb_status_chk u_chk (
  .clk(clk), .rst(rst), .poll_req_i(poll_req_i), .query_req_i(query_req_i),
  .rd_data_o(rd_data_o), .rd_vld_o(rd_vld_o), .srq_o(srq_o), .sre_o(sre_o),
  .stb(stb_w), .mss(mss_w)
);

// File: tb/tb_sb_status_top.sv
`timescale 1ns/1ps
module tb_sb_status_top;
  localparam int COND_W = 8;
  localparam int QUES_W = 16;
  localparam int OPER_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [COND_W-1:0] cond = '0;
  logic [QUES_W-1:0] qe = '0, qn = '0;
  logic [OPER_W-1:0] oe = '0, on = '0;
  logic mav = 1'b0, esb = 1'b0;
  logic sre_we = 1'b0;
  logic [7:0] sre_wd = '0;
  logic poll = 1'b0, qry = 1'b0;
  logic [7:0]  sre_o;
  logic [15:0] rd_data;
  logic        rd_vld;
  logic        srq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] sre_m = 8'h00;

  always #2.5 clk = ~clk;

  sb_status_top #(.COND_W(COND_W), .QUES_W(QUES_W), .OPER_W(OPER_W)) dut (
    .clk(clk), .rst(rst), .cond_i(cond),
    .ques_evt_i(qe), .ques_en_i(qn), .oper_evt_i(oe), .oper_en_i(on),
    .mav_i(mav), .esb_i(esb), .sre_we_i(sre_we), .sre_wdata_i(sre_wd),
    .sre_o(sre_o), .poll_req_i(poll), .query_req_i(qry),
    .rd_data_o(rd_data), .rd_vld_o(rd_vld), .srq_o(srq)
  );

  function automatic logic [7:0] m_stb();
    logic [7:0] s;
    s    = 8'h00;
    s[2] = |cond;
    s[3] = |(qe & qn);
    s[4] = mav;
    s[5] = esb;
    s[7] = |(oe & on);
    return s;
  endfunction

  function automatic logic m_mss();
    return |(m_stb() & sre_m & 8'hBF);
  endfunction

  function automatic logic [15:0] m_rd(input logic b6);
    logic [15:0] r;
    r = {8'h00, m_stb()};
    r[6] = b6;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic do_read(input bit p, input bit q, output logic [15:0] d, output logic v);
    poll = p;
    qry  = q;
    @(negedge clk);
    poll = 1'b0;
    qry  = 1'b0;
    d = rd_data;
    v = rd_vld;
  endtask

  task automatic wr_sre(input logic [7:0] d);
    sre_we = 1'b1;
    sre_wd = d;
    @(negedge clk);
    sre_we = 1'b0;
    sre_m  = d & 8'hBF;
  endtask

  task automatic clear_inputs();
    cond = '0; qe = '0; qn = '0; oe = '0; on = '0; mav = 1'b0; esb = 1'b0;
  endtask

  task automatic t_reset();
    cond = 8'hFF; mav = 1'b1;
    sre_we = 1'b1; sre_wd = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R12 rd_vld in reset", {15'd0, rd_vld}, 16'd0);
    chk("R12 rd_data in reset", rd_data, 16'd0);
    chk("R12 srq in reset", {15'd0, srq}, 16'd0);
    chk("R7 R12 sre resets to zero", {8'd0, sre_o}, 16'd0);
    sre_we = 1'b0;
    clear_inputs();
    rst = 1'b0;
    @(negedge clk);
    chk("R12 after reset rd_vld", {15'd0, rd_vld}, 16'd0);
  endtask

  task automatic t_summary_bits();
    logic [15:0] d; logic v;
    wr_sre(8'h00);
    cond = 8'h10; mav = 1'b1;
    settle();
    do_read(1'b0, 1'b1, d, v);
    chk("R2 csum/mav bits", d, m_rd(1'b0));
    chk("R8 R9 valid", {15'd0, v}, 16'd1);
    clear_inputs();
    esb = 1'b1; qe = 16'h0100; qn = 16'h0100; oe = 16'h8000; on = 16'h7FFF;
    settle();
    do_read(1'b0, 1'b1, d, v);
    chk("R3 ques hit oper miss", d, 16'h0028);
    on = 16'h8000; qn = 16'h0001;
    settle();
    do_read(1'b1, 1'b0, d, v);
    chk("R3 ques miss oper hit", d, 16'h00A0);
    chk("R1 reserved bits zero", d & 16'hFF03, 16'h0000);
    clear_inputs();
    settle();
  endtask

  task automatic t_sre_write();
    wr_sre(8'hFF);
    chk("R7 bit6 forced low", {8'd0, sre_o}, 16'h00BF);
    wr_sre(8'h5A);
    chk("R7 plain write", {8'd0, sre_o}, 16'h001A);
    sre_we = 1'b0; sre_wd = 8'hFF;
    @(negedge clk);
    chk("R7 no write without strobe", {8'd0, sre_o}, 16'h001A);
  endtask

  task automatic t_mss_rqs();
    logic [15:0] d; logic v;
    wr_sre(8'h10);
    esb = 1'b1;
    settle();
    chk("R4 disabled bit gives no request", {15'd0, srq}, 16'd0);
    do_read(1'b0, 1'b1, d, v);
    chk("R4 query bit6 zero when disabled", d, m_rd(1'b0));
    mav = 1'b1;
    @(negedge clk);
    chk("R5 not yet set one cycle after", {15'd0, srq}, 16'd0);
    @(negedge clk);
    chk("R5 srq set", {15'd0, srq}, 16'd1);
    do_read(1'b1, 1'b0, d, v);
    chk("R8 poll returns rqs", d, m_rd(1'b1));
    chk("R10 srq held after poll", {15'd0, srq}, 16'd1);
    do_read(1'b0, 1'b1, d, v);
    chk("R9 query returns mss", d, m_rd(1'b1));
    chk("R10 srq held after query", {15'd0, srq}, 16'd1);
    mav = 1'b0;
    @(negedge clk);
    chk("R6 srq still set one cycle after", {15'd0, srq}, 16'd1);
    @(negedge clk);
    chk("R6 srq cleared", {15'd0, srq}, 16'd0);
    clear_inputs();
    settle();
  endtask

  task automatic t_paths_differ();
    logic [15:0] d; logic v;
    wr_sre(8'h80);
    oe = 16'h0004; on = 16'h0004;
    @(negedge clk);
    do_read(1'b1, 1'b0, d, v);
    chk("R8 poll bit6 before rqs sets", d, m_rd(1'b0));
    chk("R5 srq set after rise", {15'd0, srq}, 16'd1);
    clear_inputs();
    settle();
    oe = 16'h0004; on = 16'h0004;
    @(negedge clk);
    do_read(1'b0, 1'b1, d, v);
    chk("R9 query bit6 before rqs sets", d, m_rd(1'b1));
    clear_inputs();
    settle();
    oe = 16'h0004; on = 16'h0004;
    @(negedge clk);
    do_read(1'b1, 1'b1, d, v);
    chk("R11 both requests give poll format", d, m_rd(1'b0));
    settle();
    rst = 1'b1;
    @(negedge clk);
    chk("R6 reset clears srq", {15'd0, srq}, 16'd0);
    rst = 1'b0;
    sre_m = 8'h00;
    clear_inputs();
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_summary_bits();
    t_sre_write();
    t_mss_rqs();
    t_paths_differ();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule